// File: doc/BRIEF.md
# PPS-Synchronized Timekeeper

This block keeps an absolute time base made of a seconds count and a tick count within the current second. The tick count advances on every cycle of the sample-rate clock. When it completes a second it returns to zero and the seconds count advances by one. Software sets a new time through a small write-only register port. It first writes a pending seconds value and a pending ticks value. It then writes a latch-mode word, which either loads that time at once or arms the block to load it on the next pulse-per-second (PPS) edge.

Two PPS inputs exist: one from an external connector and one from a board-to-board link. Each passes through a synchronizer. A flags word chooses at run time which input is used and whether its rising or falling edge counts. Whenever the chosen edge occurs, the block raises a one-cycle strobe. Downstream logic reads the current seconds and ticks directly from the output ports.

Top module: `pps_timekeeper`

## Requirements
- R1: After reset, seconds and ticks are 0, the flags word is 0 (falling edge, external input), the latch mode is next-PPS and no load is armed.
- R2: A write with `wr_en` high goes to the word chosen by `wr_addr`: 0 is the pending seconds, 1 is the pending ticks, 2 is the flags word and 3 is the latch-mode word. The write takes effect at that clock edge.
- R3: With no load, ticks grow by one each cycle. At `TICKS_PER_SEC-1`, ticks go to 0 on the next cycle and seconds grow by one. Seconds roll over from 2^32-1 to 0.
- R4: A latch-mode write whose bit 0 is 1 loads the pending seconds and ticks at that same edge, so the outputs show them exactly in the next cycle. Counting resumes from there, and any armed load is cancelled.
- R5: A latch-mode write whose bit 0 is 0 arms a load. The pending time is loaded at the edge that ends the cycle in which `pps_strobe` is high, and the arm is then cleared.
- R6: An armed load stays armed for any number of cycles until a PPS edge arrives. A later latch-mode write replaces it: an immediate write cancels the arm.
- R7: Flags bit 0 picks the PPS edge. The value 1 means rising and 0 means falling. The other edge raises no strobe and causes no load.
- R8: Flags bit 1 picks the PPS input. The value 0 selects `pps_ext` and 1 selects `pps_link`. The unselected input raises no strobe and causes no load.
- R9: Each PPS input passes through two synchronizing flops. Suppose a level change is first sampled at clock edge k. Then `pps_strobe` is high for exactly one cycle, after edge k+1, and an armed load happens at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word select |
| wr_data | input | 32 | Register write data |
| pps_ext | input | 1 | PPS from the external connector (asynchronous) |
| pps_link | input | 1 | PPS from the board-to-board link (asynchronous) |
| secs | output | 32 | Current seconds |
| ticks | output | 32 | Current ticks within the second |
| pps_strobe | output | 1 | One-cycle pulse on the selected PPS edge |

## Verification
A cycle-level scoreboard runs the counter through free counting with second wrap, and through an immediate load of the largest seconds value, which exposes the 32-bit rollover. Deferred loads are tried under each edge polarity with a full pulse on the pin. This separates the edge that must load from the edge that must not, and fixes the two-flop latency of strobe and load. With the link input selected, a pulse on the external pin shows whether the source mux really ignores it. An armed load followed by an immediate write, and then a PPS pulse, shows whether the arm is cancelled rather than applied twice.

// File: rtl/tk_pkg.sv
package tk_pkg;

    parameter int TK_W     = 32;
    parameter int TK_NREG  = 4;
    parameter int TK_AW    = $clog2(TK_NREG);
    parameter int TK_NSRC  = 2;

    typedef enum logic [TK_AW-1:0] {
        TK_A_SECS  = 2'd0,
        TK_A_TICKS = 2'd1,
        TK_A_FLAGS = 2'd2,
        TK_A_LATCH = 2'd3
    } tk_addr_e;

    typedef struct packed {
        logic [TK_W-1:0] secs;
        logic [TK_W-1:0] ticks;
    } tk_time_t;

    // bit 1: source (0 ext, 1 link); bit 0: edge (0 fall, 1 rise)
    typedef struct packed {
        logic src_link;
        logic rise_edge;
    } tk_flags_t;

    function automatic tk_time_t tk_next(tk_time_t t, logic [TK_W-1:0] last);
        tk_time_t n;
        if (t.ticks == last) begin
            n.ticks = '0;
            n.secs  = t.secs + TK_W'(1);
        end else begin
            n.ticks = t.ticks + TK_W'(1);
            n.secs  = t.secs;
        end
        return n;
    endfunction

endpackage

// File: rtl/tk_pps_sync.sv
module tk_pps_sync #(
    parameter int N_SRC       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] pin,
    output logic [N_SRC-1:0] rise,
    output logic [N_SRC-1:0] fall
);
    localparam int TOP = SYNC_STAGES;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [TOP:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[TOP-1:0], pin[g]};
        end
        assign rise[g] =  sh[TOP-1] & ~sh[TOP];
        assign fall[g] = ~sh[TOP-1] &  sh[TOP];
    end
endmodule

// File: rtl/tk_regs.sv
module tk_regs
    import tk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TK_AW-1:0]  wr_addr,
    input  logic [TK_W-1:0]   wr_data,
    output tk_time_t          pend,
    output tk_flags_t         flags,
    output logic              latch_wr,
    output logic              latch_imm
);
    tk_addr_e addr;
    assign addr      = tk_addr_e'(wr_addr);
    assign latch_wr  = wr_en && (addr == TK_A_LATCH);
    assign latch_imm = wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            flags <= '0;
        end else if (wr_en) begin
            case (addr)
                TK_A_SECS:  pend.secs  <= wr_data;
                TK_A_TICKS: pend.ticks <= wr_data;
                TK_A_FLAGS: flags      <= tk_flags_t'(wr_data[1:0]);
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/tk_clock.sv
module tk_clock
    import tk_pkg::*;
#(
    parameter logic [TK_W-1:0] TICK_LAST = '1
) (
    input  logic     clk,
    input  logic     rst,
    input  tk_time_t pend,
    input  logic     latch_wr,
    input  logic     latch_imm,
    input  logic     pps_evt,
    output tk_time_t now,
    output logic     armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            now   <= '0;
            armed <= 1'b0;
        end else begin
            if (latch_wr)     armed <= ~latch_imm;
            else if (pps_evt) armed <= 1'b0;

            if (latch_wr && latch_imm)
                now <= pend;
            else if (armed && pps_evt && !latch_wr)
                now <= pend;
            else
                now <= tk_next(now, TICK_LAST);
        end
    end
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import tk_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 100_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TK_AW-1:0] wr_addr,
    input  logic [TK_W-1:0]  wr_data,
    input  logic             pps_ext,
    input  logic             pps_link,
    output logic [TK_W-1:0]  secs,
    output logic [TK_W-1:0]  ticks,
    output logic             pps_strobe
);
    localparam logic [TK_W-1:0] TICK_LAST = TK_W'(TICKS_PER_SEC - 1);

    tk_time_t           pend_q;
    tk_flags_t          flags_q;
    tk_time_t           now_q;
    logic               latch_wr, latch_imm, armed_q;
    logic [TK_NSRC-1:0] rise, fall;
    logic               pps_evt;

    tk_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pend(pend_q), .flags(flags_q), .latch_wr(latch_wr), .latch_imm(latch_imm)
    );

    tk_pps_sync #(.N_SRC(TK_NSRC), .SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .pin({pps_link, pps_ext}), .rise(rise), .fall(fall)
    );

    assign pps_evt = flags_q.rise_edge ? rise[flags_q.src_link] : fall[flags_q.src_link];

    tk_clock #(.TICK_LAST(TICK_LAST)) u_clock (
        .clk(clk), .rst(rst), .pend(pend_q), .latch_wr(latch_wr), .latch_imm(latch_imm),
        .pps_evt(pps_evt), .now(now_q), .armed(armed_q)
    );

    assign secs       = now_q.secs;
    assign ticks      = now_q.ticks;
    assign pps_strobe = pps_evt;
endmodule

// File: rtl/tk_check.sv
module tk_check
    import tk_pkg::*;
#(
    parameter logic [TK_W-1:0] TICK_LAST = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [TK_AW-1:0] wr_addr,
    input logic             latch_bit,
    input logic             pps_strobe,
    input logic             armed,
    input logic [TK_W-1:0]  secs,
    input logic [TK_W-1:0]  ticks,
    input logic [TK_W-1:0]  pend_secs,
    input logic [TK_W-1:0]  pend_ticks
);
    logic lat_wr;
    assign lat_wr = wr_en && (wr_addr == 2'd3);

    // R4
    imm_load_chk: assert property (@(posedge clk) disable iff (rst)
        (lat_wr && latch_bit) |=> (secs == $past(pend_secs) && ticks == $past(pend_ticks) && !armed));

    // R5
    pps_load_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && pps_strobe && !lat_wr) |=> (secs == $past(pend_secs) && ticks == $past(pend_ticks) && !armed));

    // R6
    arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !pps_strobe && !lat_wr) |=> armed);

    // R3
    count_chk: assert property (@(posedge clk) disable iff (rst)
        (!lat_wr && !(armed && pps_strobe) && ticks != TICK_LAST)
        |=> (ticks == TK_W'($past(ticks) + 1) && secs == $past(secs)));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!lat_wr && !(armed && pps_strobe) && ticks == TICK_LAST)
        |=> (ticks == '0 && secs == TK_W'($past(secs) + 1)));
endmodule

bind pps_timekeeper tk_check #(.TICK_LAST(TICK_LAST)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .latch_bit(wr_data[0]),
    .pps_strobe(pps_strobe), .armed(armed_q), .secs(secs), .ticks(ticks),
    .pend_secs(pend_q.secs), .pend_ticks(pend_q.ticks)
);

// File: tb/pps_timekeeper_test.sv
module pps_timekeeper_test;
    localparam int TPS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pps_ext = 1'b0;
    logic        pps_link = 1'b0;
    logic [31:0] secs, ticks;
    logic        pps_strobe;

    always #10 clk = ~clk;

    pps_timekeeper #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pps_ext(pps_ext), .pps_link(pps_link),
        .secs(secs), .ticks(ticks), .pps_strobe(pps_strobe)
    );

    typedef struct {
        logic [31:0] s;
        logic [31:0] t;
        logic        st;
        string       tag;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench-side expectation state
    logic [31:0] m_secs = 0, m_ticks = 0, m_ps = 0, m_pt = 0;
    logic [1:0]  m_flags = 0;
    logic        m_armed = 0;
    logic [2:0]  m_sx = 0, m_sl = 0;

    function automatic logic strobe_of(logic [1:0] f, logic [2:0] sx, logic [2:0] sl);
        logic [2:0] s;
        s = f[1] ? sl : sx;
        return f[0] ? (s[1] & ~s[2]) : (~s[1] & s[2]);
    endfunction

    // one clock: derive the expected outputs after the coming edge and queue them
    task automatic cyc(input string tag);
        item_t it;
        logic ev, lw;
        ev = strobe_of(m_flags, m_sx, m_sl);
        lw = wr_en && wr_addr == 2'd3;
        if (rst) begin
            m_secs = 0; m_ticks = 0; m_ps = 0; m_pt = 0;
            m_flags = 0; m_armed = 0; m_sx = 0; m_sl = 0;
        end else begin
            if ((lw && wr_data[0]) || (m_armed && ev && !lw)) begin
                m_secs = m_ps; m_ticks = m_pt;
            end else if (m_ticks == TPS - 1) begin
                m_ticks = 0; m_secs = m_secs + 1;
            end else begin
                m_ticks = m_ticks + 1;
            end
            if (lw) m_armed = ~wr_data[0];
            else if (ev) m_armed = 1'b0;
            if (wr_en && wr_addr == 2'd0) m_ps = wr_data;
            if (wr_en && wr_addr == 2'd1) m_pt = wr_data;
            if (wr_en && wr_addr == 2'd2) m_flags = wr_data[1:0];
            m_sx = {m_sx[1:0], pps_ext};
            m_sl = {m_sl[1:0], pps_link};
        end
        it.s = m_secs; it.t = m_ticks; it.st = strobe_of(m_flags, m_sx, m_sl); it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(tag);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // monitor
    always @(posedge clk) begin
        #5;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_checks++;
            if (secs !== it.s || ticks !== it.t || pps_strobe !== it.st) begin
                n_fail++;
                $display("FAIL %s: got secs=%0d ticks=%0d strobe=%0b, expected secs=%0d ticks=%0d strobe=%0b",
                         it.tag, secs, ticks, pps_strobe, it.s, it.t, it.st);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        idle(3, "R1 reset state");
        rst = 1'b0;
        idle(45, "R3 free count and second wrap");

        wr(2'd0, 32'd100, "R2 pending secs write");
        wr(2'd1, 32'd5, "R2 pending ticks write");
        wr(2'd3, 32'd1, "R4 immediate load");
        idle(5, "R4 count resumes");

        wr(2'd0, 32'hFFFF_FFFF, "R2 pending secs write");
        wr(2'd1, 32'd17, "R2 pending ticks write");
        wr(2'd3, 32'd1, "R4 immediate load near rollover");
        idle(25, "R3 seconds rollover");

        wr(2'd2, 32'd0, "R7 falling edge external");
        wr(2'd0, 32'd500, "R2 pending secs write");
        wr(2'd1, 32'd0, "R2 pending ticks write");
        wr(2'd3, 32'd0, "R5 arm next PPS");
        idle(10, "R6 arm held without PPS");
        pps_ext = 1'b1;
        idle(6, "R7 rising edge ignored in falling mode");
        pps_ext = 1'b0;
        idle(6, "R9 R5 falling edge loads");

        wr(2'd2, 32'd1, "R7 rising edge external");
        wr(2'd0, 32'd700, "R2 pending secs write");
        wr(2'd1, 32'd3, "R2 pending ticks write");
        wr(2'd3, 32'd0, "R5 arm next PPS");
        pps_ext = 1'b1;
        idle(6, "R7 rising edge loads");
        pps_ext = 1'b0;
        idle(4, "R7 falling edge ignored in rising mode");

        wr(2'd2, 32'd3, "R8 link source rising");
        wr(2'd0, 32'd900, "R2 pending secs write");
        wr(2'd3, 32'd0, "R5 arm next PPS");
        pps_ext = 1'b1;
        idle(5, "R8 external ignored when link selected");
        pps_ext = 1'b0;
        idle(5, "R8 external ignored when link selected");
        pps_link = 1'b1;
        idle(5, "R8 link edge loads");
        pps_link = 1'b0;
        idle(3, "R8 link falling ignored");

        wr(2'd0, 32'd1000, "R2 pending secs write");
        wr(2'd3, 32'd0, "R6 arm before replacement");
        wr(2'd0, 32'd2000, "R2 pending secs write");
        wr(2'd1, 32'd2, "R2 pending ticks write");
        wr(2'd3, 32'd1, "R6 immediate write cancels arm");
        pps_link = 1'b1;
        idle(5, "R6 no load after cancel");
        pps_link = 1'b0;
        wr(2'd0, 32'd3000, "R2 pending secs write");
        wr(2'd3, 32'd0, "R6 first arm");
        wr(2'd0, 32'd4000, "R2 pending secs write");
        wr(2'd3, 32'd0, "R6 second arm replaces");
        idle(3, "R6 arm held");
        pps_link = 1'b1;
        idle(5, "R6 replaced arm loads");
        pps_link = 1'b0;
        idle(3, "R3 count after load");

        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule